// File: doc/BRIEF.md
# LFSR Sequence Self-Test Checker

This block decides whether a captured buffer of generator output words is consistent with a known linear feedback sequence. The generator is first run in a deterministic health-check setting. Its output words are then written into a local buffer through a simple write port. A start strobe launches the check. The expected value is loaded from one of two seed constants, and the block compares buffer words against it, one per clock.

Matches add to a running count that persists across scans. After every full scan that leaves the count short of the goal, the expected value moves one polynomial step forward and the buffer is scanned again. The block reports pass as soon as the count reaches the goal. It reports fail when the allowed number of scans is used up. Word 0 of the buffer is never compared, because the first captured word is not trusted.

Top module: `lfsr_selftest`

## Requirements
- R1: While rst_ni is low, and after it is released with no start, busy_o, pass_o and fail_o are all low.
- R2: A start_i sampled high on a rising edge sets busy_o and clears pass_o, fail_o and the match count, all visible after that same edge.
- R3: While busy, exactly one buffer word is compared per clock. A scan compares indices 1 to DEPTH-1 in ascending order and never compares index 0.
- R4: The expected value is loaded at start from SEED_A when seed_sel_i is 0, or from SEED_B when seed_sel_i is 1.
- R5: After each scan that ends short of the goal, the expected value x becomes (x << 1) XOR POLY if bit 63 of x was 1, and x << 1 otherwise.
- R6: The match count accumulates across scans and is cleared only by start.
- R7: When a comparison brings the count to MATCH_GOAL, pass_o is high and busy_o is low after that edge. No further words are compared.
- R8: If the goal is not met within MAX_SCANS scans, fail_o is high and busy_o is low exactly MAX_SCANS*(DEPTH-1) cycles after busy_o rose.
- R9: pass_o and fail_o are never high together, and they hold their value until the next start.
- R10: A start received while busy restarts the check from scan 0 with a cleared count and a freshly loaded seed.
- R11: wr_en_i high on a rising edge stores wr_data_i at buffer index wr_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Buffer write enable |
| wr_addr_i | input | $clog2(DEPTH) | Buffer write index |
| wr_data_i | input | WIDTH | Buffer write word |
| seed_sel_i | input | 1 | Seed select: 0 picks SEED_A, 1 picks SEED_B |
| start_i | input | 1 | Start strobe |
| busy_o | output | 1 | Check in progress |
| pass_o | output | 1 | Goal reached |
| fail_o | output | 1 | Scan limit exhausted |

## Verification
A start sampled on edge E raises busy_o after E, and the k-th comparison happens on edge E+k. A verdict reached on comparison n therefore shows after edge E+n, so busy_o is high for exactly n cycles. A pass on the third word of scan 2 with DEPTH 8 gives n = 7+7+3. A fail always gives n = MAX_SCANS*(DEPTH-1).

The bench samples every output on the falling edge, against a behavioural model that updates on the rising edge. Each scenario also counts the falling edges with busy_o high and compares that count with the n worked out above. These scenarios include a match placed only in the last allowed scan, and one placed a single scan too late.

// File: rtl/lfsr_selftest_pkg.sv
package lfsr_selftest_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;

  typedef enum logic [1:0] {
    RES_NONE = 2'b00,
    RES_PASS = 2'b01,
    RES_FAIL = 2'b10
  } verdict_e;
endpackage

// File: rtl/lfsr_selftest_buf.sv
module lfsr_selftest_buf #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  // storage has no reset: contents are always written before a check
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/lfsr_selftest_exp.sv
module lfsr_selftest_exp #(
  parameter int          WIDTH  = 64,
  parameter logic [63:0] POLY   = 64'h231D_CEE9_1262_B8A3,
  parameter logic [63:0] SEED_A = 64'h0123_4567_89AB_CDEF,
  parameter logic [63:0] SEED_B = 64'h8000_0000_0000_0001
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             seed_sel_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] exp_o
);
  logic [WIDTH-1:0] exp_q, exp_step, seed;
  logic             msb;

  assign msb  = exp_q[WIDTH-1];
  assign seed = seed_sel_i ? SEED_B[WIDTH-1:0] : SEED_A[WIDTH-1:0];

  // one Galois step: shift left, fold the outgoing bit back through POLY
  for (genvar b = 0; b < WIDTH; b++) begin : g_step
    if (b == 0) begin : g_lsb
      assign exp_step[b] = msb & POLY[b];
    end else begin : g_upper
      assign exp_step[b] = exp_q[b-1] ^ (msb & POLY[b]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      exp_q <= '0;
    else if (load_i)  exp_q <= seed;
    else if (step_i)  exp_q <= exp_step;
  end

  assign exp_o = exp_q;
endmodule

// File: rtl/lfsr_selftest_ctrl.sv
module lfsr_selftest_ctrl
  import lfsr_selftest_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int MATCH_GOAL = 4,
  parameter int MAX_SCANS  = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(MATCH_GOAL + 1),
  localparam int SCAN_W = $clog2(MAX_SCANS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             hit_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             step_o,
  output logic             busy_o,
  output logic             pass_o,
  output logic             fail_o
);
  scan_state_e       state_q;
  verdict_e          verdict_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SCAN_W-1:0] scan_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              busy, last_idx, last_scan, goal_hit;

  assign busy      = (state_q == ST_SCAN);
  assign cnt_nxt   = cnt_q + CNT_W'(hit_i & busy);
  assign goal_hit  = busy && (cnt_nxt >= CNT_W'(MATCH_GOAL));
  assign last_idx  = (idx_q == IDX_W'(DEPTH - 1));
  assign last_scan = (scan_q == SCAN_W'(MAX_SCANS - 1));
  assign step_o    = busy && !start_i && !goal_hit && last_idx && !last_scan;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      verdict_q <= RES_NONE;
      idx_q     <= IDX_W'(1);
      scan_q    <= '0;
      cnt_q     <= '0;
    end else if (start_i) begin
      state_q   <= ST_SCAN;
      verdict_q <= RES_NONE;
      idx_q     <= IDX_W'(1);
      scan_q    <= '0;
      cnt_q     <= '0;
    end else if (busy) begin
      cnt_q <= cnt_nxt;
      if (goal_hit) begin
        state_q   <= ST_IDLE;
        verdict_q <= RES_PASS;
      end else if (last_idx) begin
        idx_q <= IDX_W'(1);  // word 0 is never scanned
        if (last_scan) begin
          state_q   <= ST_IDLE;
          verdict_q <= RES_FAIL;
        end else begin
          scan_q <= scan_q + SCAN_W'(1);
        end
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

  assign rd_idx_o = idx_q;
  assign busy_o   = busy;
  assign pass_o   = (verdict_q == RES_PASS);
  assign fail_o   = (verdict_q == RES_FAIL);
endmodule

// File: rtl/lfsr_selftest.sv
module lfsr_selftest #(
  parameter int          WIDTH      = 64,
  parameter int          DEPTH      = 16,
  parameter int          MATCH_GOAL = 4,
  parameter int          MAX_SCANS  = 8,
  parameter logic [63:0] POLY       = 64'h231D_CEE9_1262_B8A3,
  parameter logic [63:0] SEED_A     = 64'h0123_4567_89AB_CDEF,
  parameter logic [63:0] SEED_B     = 64'h8000_0000_0000_0001,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             seed_sel_i,
  input  logic             start_i,
  output logic             busy_o,
  output logic             pass_o,
  output logic             fail_o
);
  logic [IDX_W-1:0] rd_idx;
  logic [WIDTH-1:0] rd_data, exp_val;
  logic             step;

  lfsr_selftest_buf #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_buf (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (rd_data)
  );

  lfsr_selftest_exp #(
    .WIDTH(WIDTH), .POLY(POLY), .SEED_A(SEED_A), .SEED_B(SEED_B)
  ) u_exp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_i),
    .seed_sel_i (seed_sel_i),
    .step_i     (step),
    .exp_o      (exp_val)
  );

  lfsr_selftest_ctrl #(
    .DEPTH(DEPTH), .MATCH_GOAL(MATCH_GOAL), .MAX_SCANS(MAX_SCANS)
  ) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .hit_i    (rd_data == exp_val),
    .rd_idx_o (rd_idx),
    .step_o   (step),
    .busy_o   (busy_o),
    .pass_o   (pass_o),
    .fail_o   (fail_o)
  );
endmodule

// File: rtl/lfsr_selftest_chk.sv
module lfsr_selftest_chk #(
  parameter int DEPTH     = 16,
  parameter int MAX_SCANS = 8,
  localparam int LIMIT = MAX_SCANS * (DEPTH - 1),
  localparam int CYC_W = $clog2(LIMIT + 1) + 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic pass_o,
  input logic fail_o
);
  logic [CYC_W-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cyc_q <= '0;
    else if (start_i) cyc_q <= '0;
    else if (busy_o)  cyc_q <= cyc_q + CYC_W'(1);
  end

  p_busy_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_o && !pass_o && !fail_o));

  p_busy_clean_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!pass_o && !fail_o));

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> (!busy_o && $stable(pass_o) && $stable(fail_o)));

  p_end_verdict_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> (busy_o || (pass_o != fail_o)));

  p_fail_window_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> (cyc_q == CYC_W'(LIMIT)));
endmodule

bind lfsr_selftest lfsr_selftest_chk #(.DEPTH(DEPTH), .MAX_SCANS(MAX_SCANS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .pass_o  (pass_o),
  .fail_o  (fail_o)
);

// File: tb/lfsr_selftest_tb_top.sv
module lfsr_selftest_tb_top;
  localparam int          DEPTH = 8;
  localparam int          GOAL  = 3;
  localparam int          SCANS = 5;
  localparam logic [63:0] POLY  = 64'h231D_CEE9_1262_B8A3;
  localparam logic [63:0] SA    = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] SB    = 64'h8000_0000_0000_0001;
  localparam int          SPAN  = DEPTH - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [63:0] wr_data = '0;
  logic        seed_sel = 1'b0;
  logic        start = 1'b0;
  logic        busy, pass, fail;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lfsr_selftest #(
    .DEPTH(DEPTH), .MATCH_GOAL(GOAL), .MAX_SCANS(SCANS),
    .POLY(POLY), .SEED_A(SA), .SEED_B(SB)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .seed_sel_i(seed_sel), .start_i(start),
    .busy_o(busy), .pass_o(pass), .fail_o(fail)
  );

  function automatic logic [63:0] nxt(input logic [63:0] v);
    logic [63:0] r;
    r = v << 1;
    if (v[63]) r = r ^ POLY;
    return r;
  endfunction

  function automatic logic [63:0] st(input logic [63:0] s, input int n);
    logic [63:0] v = s;
    for (int i = 0; i < n; i++) v = nxt(v);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference
  logic [63:0] m_buf [DEPTH];
  logic [63:0] m_exp;
  int m_cnt, m_idx, m_scan;
  bit m_busy, m_pass, m_fail;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_pass = 0; m_fail = 0; m_cnt = 0; m_idx = 1; m_scan = 0; m_exp = '0;
    end else begin
      if (start) begin
        m_busy = 1; m_pass = 0; m_fail = 0; m_cnt = 0; m_idx = 1; m_scan = 0;
        m_exp = seed_sel ? SB : SA;
      end else if (m_busy) begin
        if (m_buf[m_idx] == m_exp) m_cnt++;
        if (m_cnt >= GOAL) begin
          m_busy = 0; m_pass = 1;
        end else if (m_idx == DEPTH - 1) begin
          m_idx = 1;
          if (m_scan == SCANS - 1) begin
            m_busy = 0; m_fail = 1;
          end else begin
            m_scan++; m_exp = nxt(m_exp);
          end
        end else m_idx++;
      end
      if (wr_en) m_buf[wr_addr] = wr_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(busy == m_busy, "R3 busy per cycle", 64'(busy), 64'(m_busy));
      chk(pass == m_pass, "R7 pass per cycle", 64'(pass), 64'(m_pass));
      chk(fail == m_fail, "R8 fail per cycle", 64'(fail), 64'(m_fail));
    end
  end

  task automatic wr(input int a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic junk();
    for (int i = 0; i < DEPTH; i++) wr(i, 64'hA5A5_0000_0000_0000 + 64'(i));
  endtask

  task automatic kick(input bit sel);
    @(negedge clk);
    start = 1'b1; seed_sel = sel;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !pass && !fail, "R2 start clears", {61'd0, busy, pass, fail}, 64'h4);
  endtask

  task automatic finish_run(input bit exp_pass, input int exp_lat, input string req);
    int n = 1;
    while (busy && n < 1000) begin
      @(negedge clk);
      if (busy) n++;
    end
    chk(pass == exp_pass && fail == !exp_pass, req, {62'd0, pass, fail}, {62'd0, exp_pass, !exp_pass});
    chk(n == exp_lat, {req, " latency"}, 64'(n), 64'(exp_lat));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !pass && !fail, "R1 in reset", {61'd0, busy, pass, fail}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !pass && !fail, "R1 after reset", {61'd0, busy, pass, fail}, 64'h0);

    // R11 R6: three matches in scan 0, the last at index 6
    junk(); wr(2, SA); wr(4, SA); wr(6, SA);
    kick(1'b0); finish_run(1'b1, 6, "R11 R7 single-scan pass");

    // R4: same buffer with the other seed never matches
    kick(1'b1); finish_run(1'b0, SCANS * SPAN, "R4 seed select B mismatch");

    // R3: word 0 is skipped, two matches total is short of goal
    junk(); wr(0, SA); wr(3, SA); wr(5, SA);
    kick(1'b0); finish_run(1'b0, SCANS * SPAN, "R3 word0 skipped");

    // R5 R6: one state per scan, goal reached in scan 2 at index 3
    junk(); wr(1, st(SB, 0)); wr(2, st(SB, 1)); wr(3, st(SB, 2));
    kick(1'b1); finish_run(1'b1, 2 * SPAN + 3, "R5 R6 accumulate across scans");

    // R8 boundary: third match only in the last allowed scan
    junk(); wr(1, st(SA, 0)); wr(2, st(SA, 1)); wr(7, st(SA, SCANS - 1));
    kick(1'b0); finish_run(1'b1, SCANS * SPAN, "R8 pass in last scan");

    // R9: verdict holds while idle
    repeat (4) @(negedge clk);
    chk(pass && !fail && !busy, "R9 verdict held", {61'd0, busy, pass, fail}, 64'h2);

    // R8: third match one scan too late
    wr(7, st(SA, SCANS));
    kick(1'b0); finish_run(1'b0, SCANS * SPAN, "R8 fail one scan late");

    // R10: restart mid-run
    kick(1'b0);
    repeat (9) @(negedge clk);
    start = 1'b1; seed_sel = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !pass && !fail, "R10 restart busy", {61'd0, busy, pass, fail}, 64'h4);
    finish_run(1'b0, SCANS * SPAN, "R10 restart full window");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule